// File: doc/BRIEF.md
# Asynchronous SRAM Bridge

This block lets an on-chip host perform single-byte reads and writes on an external asynchronous static RAM of 1M x 8. The host side is a valid/ready request stream with a one-cycle response strobe. The memory side drives the address lines and a chip-select pair of opposite polarity (active-low `mem_sel_n` and active-high `mem_sel`, both asserted only for the duration of an access). It also drives active-low output-enable and write-enable, and a split tri-state data bus (`mem_dq_out`, `mem_dq_oe`, `mem_dq_in`).

Memory timing is given as nanosecond parameters together with the clock period. Every window is turned into a clock-cycle count by rounding up. The defaults assume a 10 ns clock and the 55 ns speed grade, which gives a 6-cycle read, a 5-cycle write-enable pulse, a 6-cycle write and a 2-cycle bus turnaround. When no access is running, the memory is deselected with both strobes high and the bridge's data drivers off.

Request stream rules: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the transfer edge through the response cycle, and `req_valid` has no effect while it is low. The response (`rsp_valid`) cannot be back-pressured, so the host must take it in the cycle it appears.

Top module: `sram_bridge`

## Requirements
- R1: During reset and after reset, `mem_sel_n`=1, `mem_sel`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: The memory is selected only as the pair `mem_sel_n`=0 with `mem_sel`=1. Both pins change on the same edge, and they are selected only in read or write cycles.
- R3: A read transfer selects the memory and drives `mem_oe_n` low for RD_CYC = max(ceil(tRC), ceil(tAA), ceil(tOE)) cycles (6 by default), starting on the transfer edge. The byte on `mem_dq_in` is sampled at the edge that ends that window and is presented on `rsp_rdata` in the next cycle.
- R4: A write drives `mem_we_n` low for WE_CYC = max of ceil(tWP), ceil(tCW), ceil(tAW), ceil(tDW) cycles (5 by default). It drives `mem_dq_oe`=1 with the request byte on `mem_dq_out` from the first of those cycles until the memory is deselected.
- R5: A write keeps the memory selected for WC_CYC = max(WE_CYC, ceil(tWC)) cycles (6 by default). `mem_we_n` is high, with data still driven, in the cycles after the pulse.
- R6: `mem_oe_n` stays high during every write cycle and whenever `mem_dq_oe` is 1.
- R7: `mem_dq_oe` rises no sooner than TURN_CYC = ceil(tHZ) edges after the edge that ended a read. A write arriving earlier waits with the memory deselected.
- R8: `req_ready` is low from the transfer edge through the response cycle. `req_valid` while `req_ready` is low starts nothing and changes no memory pin.
- R9: Each access gives exactly one `rsp_valid` cycle, directly after the memory is deselected.
- R10: A write that does not come within TURN_CYC edges of a read's end starts on its transfer edge with no idle cycle.
- R11: `mem_addr` equals the transferred request address in every selected cycle of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Byte read, valid with `rsp_valid` after a read |
| mem_addr | output | 20 | Memory address lines |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven to memory |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_in | input | 8 | Data received from memory |

## Verification
The two functions that can coincide are accepting a new write and the bus-turnaround hold that follows a read. The bench builds the bridge with a long release time, so that a write issued right after a read's response lands inside the hold. Its reference model predicts the exact number of deselected wait cycles and the edge on which the drivers turn on, and it compares every pin each cycle. A second overlap happens when a request is held valid across a busy access and its response cycle. The model shows that nothing is accepted then, and a later read of the ignored write's address returns the untouched content.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GAP,
    PH_READ,
    PH_WLOW,
    PH_WREC,
    PH_ACK
  } phase_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_bridge_timer.sv
module sram_bridge_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

  // R3 / R5: an expired window stays expired until reloaded
  a_r5_timer_rests: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/sram_bridge_turn.sv
module sram_bridge_turn #(
  parameter int TURN_CYC = 2,
  parameter int W        = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_done,
  output logic clear
);

  logic [W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (rd_done) begin
      left <= W'(TURN_CYC);
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  // the coming edge is at least TURN_CYC edges past the read's end
  assign clear = (left <= W'(1));

  // R7: the hold never grows on its own
  a_r7_hold_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_done && left != '0) |=> (left < $past(left)));

endmodule

// File: rtl/sram_bridge_seq.sv
module sram_bridge_seq
  import sram_bridge_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int RD_CYC   = 6,
  parameter int WE_CYC   = 5,
  parameter int WREC_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_zero,
  input  logic             turn_clear,
  output logic             req_ready,
  output logic             accept,
  output logic             rd_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output phase_e           phase_d
);

  phase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_ready && req_valid;
  assign rd_done   = (phase_q == PH_READ) && tmr_zero;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          if (!req_write) begin
            phase_d  = PH_READ;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RD_CYC - 1);
          end else if (turn_clear) begin
            phase_d  = PH_WLOW;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(WE_CYC - 1);
          end else begin
            phase_d  = PH_GAP;
          end
        end
      end
      PH_GAP: begin
        if (turn_clear) begin
          phase_d  = PH_WLOW;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WE_CYC - 1);
        end
      end
      PH_READ: begin
        if (tmr_zero) phase_d = PH_ACK;
      end
      PH_WLOW: begin
        if (tmr_zero) begin
          if (WREC_CYC > 0) begin
            phase_d  = PH_WREC;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(WREC_CYC - 1);
          end else begin
            phase_d  = PH_ACK;
          end
        end
      end
      PH_WREC: begin
        if (tmr_zero) phase_d = PH_ACK;
      end
      PH_ACK:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  // R8: a busy bridge leaves idle only through the response phase
  a_r8_idle_via_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && phase_q != PH_ACK) |=> (phase_q != PH_IDLE));

endmodule

// File: rtl/sram_bridge_pins.sv
module sram_bridge_pins
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_d,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic sel_d;
  logic drive_d;

  assign sel_d   = (phase_d == PH_READ) || (phase_d == PH_WLOW) || (phase_d == PH_WREC);
  assign drive_d = (phase_d == PH_WLOW) || (phase_d == PH_WREC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_sel_n  <= 1'b1;
      mem_sel    <= 1'b0;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (accept) mem_addr <= req_addr;
      if (accept && req_write) mem_dq_out <= req_wdata;
      mem_sel_n <= !sel_d;
      mem_sel   <= sel_d;
      mem_oe_n  <= (phase_d != PH_READ);
      mem_we_n  <= (phase_d != PH_WLOW);
      mem_dq_oe <= drive_d;
      rsp_valid <= (phase_d == PH_ACK);
      if (rd_done) rsp_rdata <= mem_dq_in;
    end
  end

  // R2: a write strobe only ever appears on a selected device
  a_r2_we_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_sel_n && mem_sel));

  // R6: never ask the memory to drive while our drivers are on
  a_r6_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R4: write data and address hold while the bus is driven
  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> ($stable(mem_dq_out) && $stable(mem_addr)));

  // R9: the response strobe lasts one cycle
  a_r9_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3: closing a read window is followed by its response
  a_r3_ack_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> rsp_valid);

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_OE_NS = 25,
  parameter int T_WC_NS = 55,
  parameter int T_WP_NS = 40,
  parameter int T_CW_NS = 45,
  parameter int T_AW_NS = 45,
  parameter int T_DW_NS = 25,
  parameter int T_HZ_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                               imax(ns_to_cyc(T_OE_NS, CLK_NS), 1));
  localparam int WE_CYC = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_CW_NS, CLK_NS)),
                               imax(imax(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)), 1));
  localparam int WC_CYC   = imax(ns_to_cyc(T_WC_NS, CLK_NS), WE_CYC);
  localparam int WREC_CYC = WC_CYC - WE_CYC;
  localparam int TURN_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int CNT_W    = $clog2(imax(RD_CYC, WC_CYC) + 1);
  localparam int TURN_W   = $clog2(TURN_CYC + 2);

  phase_e             phase_d;
  logic               accept;
  logic               rd_done;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic               tmr_zero;
  logic               turn_clear;

  sram_bridge_seq #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .WREC_CYC(WREC_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .tmr_zero(tmr_zero), .turn_clear(turn_clear), .req_ready(req_ready),
    .accept(accept), .rd_done(rd_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .phase_d(phase_d)
  );

  sram_bridge_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sram_bridge_turn #(.TURN_CYC(TURN_CYC), .W(TURN_W)) u_turn (
    .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .clear(turn_clear)
  );

  sram_bridge_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase_d(phase_d), .accept(accept),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_done(rd_done), .mem_dq_in(mem_dq_in), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // edges elapsed since output-enable was last low, saturating
  logic [TURN_W-1:0] since_rd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         since_rd <= TURN_W'(TURN_CYC + 1);
    else if (!mem_oe_n)                 since_rd <= TURN_W'(1);
    else if (since_rd <= TURN_W'(TURN_CYC)) since_rd <= since_rd + 1'b1;
  end

  // R7: drivers turn on only after the release window
  a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (since_rd > TURN_W'(TURN_CYC)));

  // R8: no new request is taken in the response cycle
  a_r8_busy_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R11: the address holds through consecutive selected cycles
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && !$past(mem_sel_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_bridge_test.sv
module sram_bridge_test;

  // expected cycle counts: 10 ns clock, 55 ns grade, release 45 ns
  localparam int RD   = (55 + 9) / 10;
  localparam int WE   = (45 + 9) / 10;
  localparam int WC   = (55 + 9) / 10;
  localparam int TURN = (45 + 9) / 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [19:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'h5A;

  always #2 clk = ~clk;

  sram_bridge #(.CLK_NS(10), .T_HZ_NS(45)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit chk_on  = 0;

  function automatic logic [7:0] init_val(input logic [19:0] a);
    return a[7:0] ^ a[19:12] ^ 8'h3C;
  endfunction

  // memory device model, driven from the pins
  logic [7:0] dev_mem [int];
  always @(negedge clk) begin
    if (!mem_sel_n && mem_sel && !mem_we_n) dev_mem[int'(mem_addr)] = mem_dq_out;
    if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n)
      mem_dq_in <= dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : init_val(mem_addr);
    else
      mem_dq_in <= 8'h5A;
  end

  // reference model: per-cycle expected pins, built from requests
  typedef struct {
    bit sel; bit oe_n; bit we_n; bit doe; bit rv; bit rdy;
    bit chk_d; logic [7:0] d; logic [19:0] a; logic [7:0] wd;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  logic [7:0] ref_mem [int];
  int edge_n = 0;
  int last_rd_end = -1000;

  function automatic exp_t mk(bit sel, bit oe_n, bit we_n, bit doe, bit rv, bit rdy);
    exp_t e;
    e.sel = sel; e.oe_n = oe_n; e.we_n = we_n; e.doe = doe; e.rv = rv; e.rdy = rdy;
    e.chk_d = 0; e.d = '0; e.a = '0; e.wd = '0;
    return e;
  endfunction

  function automatic logic [7:0] ref_rd(input logic [19:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
  endfunction

  initial cur = mk(0, 1, 1, 0, 0, 1);

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = mk(0, 1, 1, 0, 0, 1);
    end else begin
      exp_t e;
      edge_n++;
      if (cur.rdy && req_valid) begin
        if (!req_write) begin
          for (int i = 0; i < RD; i++) begin
            e = mk(1, 0, 1, 0, 0, 0); e.a = req_addr; q.push_back(e);
          end
          e = mk(0, 1, 1, 0, 1, 0); e.chk_d = 1; e.d = ref_rd(req_addr); q.push_back(e);
          last_rd_end = edge_n + RD;
        end else begin
          int w;
          w = last_rd_end + TURN - edge_n;
          for (int i = 0; i < w; i++) q.push_back(mk(0, 1, 1, 0, 0, 0));
          for (int i = 0; i < WC; i++) begin
            e = mk(1, 1, (i < WE) ? 1'b0 : 1'b1, 1, 0, 0);
            e.a = req_addr; e.wd = req_wdata; q.push_back(e);
          end
          q.push_back(mk(0, 1, 1, 0, 1, 0));
          ref_mem[int'(req_addr)] = req_wdata;
        end
      end
      cur = (q.size() != 0) ? q.pop_front() : mk(0, 1, 1, 0, 0, 1);
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      bit rs;
      rs = !rst_n;
      chk(mem_sel_n == !cur.sel, rs ? "R1" : "R2", "mem_sel_n", mem_sel_n, !cur.sel);
      chk(mem_sel == cur.sel, rs ? "R1" : "R2/R5", "mem_sel", mem_sel, cur.sel);
      chk(mem_oe_n == cur.oe_n, rs ? "R1" : "R3/R6", "mem_oe_n", mem_oe_n, cur.oe_n);
      chk(mem_we_n == cur.we_n, rs ? "R1" : "R4/R10", "mem_we_n", mem_we_n, cur.we_n);
      chk(mem_dq_oe == cur.doe, rs ? "R1" : "R7", "mem_dq_oe", mem_dq_oe, cur.doe);
      chk(rsp_valid == cur.rv, rs ? "R1" : "R9", "rsp_valid", rsp_valid, cur.rv);
      chk(req_ready == cur.rdy, rs ? "R1" : "R8", "req_ready", req_ready, cur.rdy);
      if (cur.sel) chk(mem_addr == cur.a, "R11", "mem_addr", mem_addr, cur.a);
      if (cur.doe) chk(mem_dq_out == cur.wd, "R4", "mem_dq_out", mem_dq_out, cur.wd);
      if (cur.chk_d) chk(rsp_rdata == cur.d, "R3", "rsp_rdata", rsp_rdata, cur.d);
    end
  end

  task automatic send(input bit w, input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  // R8: request held while busy, with a different write behind it
  task automatic send_busy(input logic [19:0] a, input logic [19:0] b);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_write = 1; req_addr = b; req_wdata = 8'hEE;
    repeat (RD) @(negedge clk);
    req_valid = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    chk_on = 1;
    settle(3);                       // R1 checked while in reset
    rst_n = 1;
    settle(2);                       // R1 after release
    send(1, 20'h00000, 8'h11);       // R4 R5 R11 lowest address
    send(1, 20'hFFFFF, 8'hFF);       // R10 write after write, top address
    send(1, 20'h12345, 8'h00);
    send(0, 20'hFFFFF, 8'h00);       // R3 read back
    send(1, 20'h00010, 8'hA7);       // R7 write inside the release window
    send(0, 20'h00000, 8'h00);
    send(0, 20'h55555, 8'h00);       // R3 untouched location
    send_busy(20'h12345, 20'h0ABCD); // R8 held request ignored
    settle(4);
    send(0, 20'h0ABCD, 8'h00);       // R8 the ignored write left no trace
    settle(TURN + 3);
    send(1, 20'h0ABCD, 8'h5C);       // R10 write well after a read
    send(0, 20'h0ABCD, 8'h00);
    send(0, 20'h00010, 8'h00);
    settle(12);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL R8 watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule